// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block holds a bank of 32-bit mailboxes for signalling between cores and for handing off boot information. The default build has four cores with four mailboxes each, sixteen in total. Software reaches every mailbox through two aliases in a small register window. A write to the set alias ORs the written ones into the mailbox. A write to the clear alias removes exactly the bits written as one. Both aliases read back the mailbox's current contents.

Each mailbox drives one pending line. That line is high for as long as any bit in the mailbox is nonzero. The pending lines are grouped four per core. An interrupt router outside this block applies enables and picks the delivery class. This bank only stores, decodes and flags.

Accesses use a simple single-cycle register bus. A write is committed on the rising edge where select and write are both high. Read data is combinational and is valid in the same cycle as a read access. When no read is in progress, the read data is zero.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox holds zero, all pending lines are low, and reads return zero.
- R2: A write to a set alias ORs the write data into the addressed mailbox. Bits already set stay set.
- R3: A write to a clear alias clears exactly the bits written as 1 and leaves all other bits unchanged.
- R4: Pending line index 4*core+n (core c occupies bits 4c..4c+3) is high exactly while mailbox n of core c is nonzero. It is updated in the cycle after the write.
- R5: A read of a clear alias returns the current mailbox value.
- R6: A read of a set alias returns the current mailbox value.
- R7: Mailbox n of core c sits at set alias 0x80 + 16c + 4n and at clear alias 0xC0 + 16c + 4n. A write changes only the addressed mailbox.
- R8: Offsets below 0x80 and offsets whose two low bits are not zero are unmapped. They read as zero, and writes to them change no mailbox.
- R9: A read does not change any mailbox or pending line. The mailbox model lets a set and a clear that reach the same mailbox in one cycle resolve with the set winning on overlapping bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read, zero otherwise |
| mbox_pend | output | 16 | Pending lines, bit 4*core+n for mailbox n of core c |

## Verification
The assertions assume at most one bus access per cycle. They also assume that all inputs are stable around the rising edge, and that reset is held long enough for the internal synchronizer to settle. The bench changes inputs only on falling edges, issues a single access at a time, and holds reset for several cycles before it releases it on a falling edge. The claim that a pending line can rise only after a set write at its own index depends on the bus being the only source of change for a mailbox.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Kind of a write access after decoding
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_MBOX = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  localparam int IDX_W   = $clog2(NUM_MBOX),
  localparam int SPAN    = NUM_MBOX * 4
) (
  input  logic             acc_sel,
  input  logic             acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output acc_kind_e        wr_kind,
  output logic             rd_hit,
  output logic [IDX_W-1:0] word_idx
);
  logic              aligned;
  logic              in_set;
  logic              in_clr;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    aligned = (acc_addr[1:0] == 2'b00);
    in_set  = aligned && (int'(acc_addr) >= SET_BASE) && (int'(acc_addr) < SET_BASE + SPAN);
    in_clr  = aligned && (int'(acc_addr) >= CLR_BASE) && (int'(acc_addr) < CLR_BASE + SPAN);
    offset  = in_clr ? (acc_addr - ADDR_W'(CLR_BASE)) : (acc_addr - ADDR_W'(SET_BASE));
    word_idx = offset[IDX_W+1:2];
    rd_hit  = acc_sel && !acc_wr && (in_set || in_clr);
    wr_kind = ACC_NONE;
    if (acc_sel && acc_wr) begin
      if (in_set)      wr_kind = ACC_SET;
      else if (in_clr) wr_kind = ACC_CLR;
    end
  end
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              pend
);
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] value_d;
  logic              upd_en;

  // next state: clear first, then OR in set bits (set wins on overlap)
  always_comb begin
    upd_en  = set_en || clr_en;
    value_d = value_q;
    if (clr_en) value_d = value_d & ~wdata;
    if (set_en) value_d = value_d | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (upd_en) value_q <= value_d;
  end

  assign value = value_q;
  assign pend  = |value_q;

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((value_q & $past(wdata)) == $past(wdata)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((value_q & $past(wdata)) == '0));

  assert_clr_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((value_q & ~$past(wdata)) == ($past(value_q) & ~$past(wdata))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(value_q));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int MBOX_PER_CORE = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int SET_BASE      = 'h80,
  parameter int CLR_BASE      = 'hC0,
  localparam int NUM_MBOX     = NUM_CORES * MBOX_PER_CORE,
  localparam int IDX_W        = $clog2(NUM_MBOX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_MBOX-1:0] mbox_pend
);
  logic             rst_sync_n;
  acc_kind_e        wr_kind;
  logic             rd_hit;
  logic [IDX_W-1:0] word_idx;
  logic [DATA_W-1:0] mb_val [NUM_MBOX];

  mbox_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  mbox_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_MBOX(NUM_MBOX),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
  ) u_dec (
    .acc_sel (bus_sel),
    .acc_wr  (bus_wr),
    .acc_addr(bus_addr),
    .wr_kind (wr_kind),
    .rd_hit  (rd_hit),
    .word_idx(word_idx)
  );

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbox
    logic hit;
    assign hit = (word_idx == IDX_W'(i));

    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_en(hit && (wr_kind == ACC_SET)),
      .clr_en(hit && (wr_kind == ACC_CLR)),
      .wdata (bus_wdata),
      .value (mb_val[i]),
      .pend  (mbox_pend[i])
    );

    assert_pend_rise_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(mbox_pend[i]) |-> $past(bus_sel && bus_wr && (wr_kind == ACC_SET) && (word_idx == IDX_W'(i))));
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) bus_rdata = mb_val[word_idx];
  end

  assert_unmapped_low_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && (int'(bus_addr) < SET_BASE)) |-> ((wr_kind == ACC_NONE) && !rd_hit));

  assert_misaligned_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && (bus_addr[1:0] != 2'b00)) |-> ((wr_kind == ACC_NONE) && (bus_rdata == '0)));

  assert_read_still_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr) |=> $stable(mbox_pend));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (mbox_pend == '0));
endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] mbox_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbox_bank uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .mbox_pend(mbox_pend)
  );

  // {req[3:0], is_read, addr[7:0], wdata[31:0], expected[31:0]}
  localparam int NVEC = 16;
  localparam logic [76:0] VEC [NVEC] = '{
    {4'd2, 1'b0, 8'h80, 32'h0000_00A5, 32'h0},            // R2 set core0 mb0
    {4'd5, 1'b1, 8'hC0, 32'h0,         32'h0000_00A5},    // R5 read clear alias
    {4'd2, 1'b0, 8'h80, 32'h0000_5A00, 32'h0},            // R2 OR more bits
    {4'd6, 1'b1, 8'h80, 32'h0,         32'h0000_5AA5},    // R6 read set alias
    {4'd3, 1'b0, 8'hC0, 32'h0000_0A05, 32'h0},            // R3 partial clear
    {4'd3, 1'b1, 8'hC0, 32'h0,         32'h0000_50A0},    // R3 result
    {4'd7, 1'b0, 8'hBC, 32'hFFFF_FFFF, 32'h0},            // R7 core3 mb3 set
    {4'd3, 1'b0, 8'hFC, 32'h8000_0001, 32'h0},            // R3 clear edges
    {4'd7, 1'b1, 8'hBC, 32'h0,         32'h7FFF_FFFE},    // R7 same mailbox
    {4'd7, 1'b0, 8'h94, 32'h1234_0000, 32'h0},            // R7 core1 mb1 set
    {4'd7, 1'b1, 8'hD4, 32'h0,         32'h1234_0000},    // R7 read back
    {4'd7, 1'b1, 8'hC4, 32'h0,         32'h0000_0000},    // R7 neighbour untouched
    {4'd8, 1'b0, 8'h40, 32'hFFFF_FFFF, 32'h0},            // R8 unmapped write
    {4'd8, 1'b1, 8'h40, 32'h0,         32'h0000_0000},    // R8 unmapped read
    {4'd8, 1'b0, 8'h81, 32'h0000_00FF, 32'h0},            // R8 misaligned write
    {4'd8, 1'b1, 8'hC0, 32'h0,         32'h0000_50A0}     // R8 no change
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pending after reset", {16'h0, mbox_pend}, 32'h0);
    bus_read(8'hC0, rd);
    chk("R1 mailbox after reset", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [76:0] v;
      v = VEC[i];
      if (v[72]) begin
        bus_read(v[71:64], rd);
        chk($sformatf("R%0d vector %0d", v[76:73], i), rd, v[31:0]);
      end else begin
        bus_write(v[71:64], v[63:32]);
      end
    end

    // R4 pending map: core0 mb0, core1 mb1, core3 mb3
    chk("R4 pending pattern", {16'h0, mbox_pend}, 32'h0000_8021);

    // R9 reads do not alter contents or pending
    bus_read(8'hD4, rd);
    bus_read(8'h94, rd2);
    chk("R9 repeated read", rd2, rd);
    chk("R9 pending after reads", {16'h0, mbox_pend}, 32'h0000_8021);

    // R4 pending drops when mailbox empties, stays while bits remain
    bus_write(8'hC0, 32'hFFFF_FFFF);
    chk("R4 pending after full clear", {16'h0, mbox_pend}, 32'h0000_8020);
    bus_write(8'hD4, 32'h0034_0000);
    chk("R4 pending with bits left", {16'h0, mbox_pend}, 32'h0000_8020);
    bus_read(8'h94, rd);
    chk("R3 partial clear core1", rd, 32'h1200_0000);

    // R2 set on a fresh mailbox raises only its line (core2 mb2 -> bit 10)
    bus_write(8'hA8, 32'h0000_0001);
    chk("R4 core2 mb2 line", {16'h0, mbox_pend}, 32'h0000_8420);

    // R1 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pending in reset", {16'h0, mbox_pend}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(8'hBC, rd);
    chk("R1 mailbox after second reset", rd, 32'h0);

    finish_run();
  end
endmodule